// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending side of an asynchronous serial port. A host places one character at a time into a single-entry holding register. The transmitter moves that character into its shift register and sends it on a serial line as a framed bit stream: a low start bit, then the data bits least significant first, then a high stop bit. The line advances one bit on each pulse of an external baud tick. A character written while a frame is still on the line waits in the holding register, so the next frame can follow the current one with no idle gap.

Two word sizes are available. In the 8-bit format the frame is 10 bits long. In the 9-bit format it is 11 bits long, and the extra data bit comes from a separate control input that is sampled when the shift register loads. Two status flags tell the host when it may write again and when the line has gone quiet. These are the holding-register-empty flag and the transmit-complete flag. Each flag drives an interrupt request through its own enable.

Top module: `sertx_dbuf`

## Requirements
- R1: Once reset has been released, `ser_out` is 1, `dre_flag` is 1, `tc_flag` is 0 and both interrupt requests are 0.
- R2: When `nine_mode` is 0 at load, the frame is 10 bits: a 0 start bit, `wr_data` bits 0 through 7 in that order, then a 1 stop bit.
- R3: When `nine_mode` is 1 at load, the frame is 11 bits: start, 8 data bits LSB first, then the value that `ninth_bit` had in the load cycle, then the stop bit.
- R4: During a frame, `ser_out` changes only after a clock edge at which `baud_tick` was 1. Each tick advances the line by exactly one bit.
- R5: A write while the transmitter is enabled and idle fills the holding register at that edge. The next edge loads the shift register, and `ser_out` then shows the start bit.
- R6: A write made during a frame waits in the holding register. It loads at the same edge where the tick ends the current stop bit, so its start bit follows immediately.
- R7: `dre_flag` goes to 0 at the edge of any write. It returns to 1 at the edge where the waiting character moves into the shift register.
- R8: A second write while the holding register is full replaces the waiting character, and only the newest character is sent.
- R9: `tc_flag` goes to 1 at the tick that ends a stop bit when no character is waiting. It stays 0 when a waiting character loads at that tick.
- R10: `tc_flag` is cleared by a `tc_clr` pulse or by a write. If a set and a `tc_clr` pulse fall on the same edge, the set wins.
- R11: `dre_irq` equals `dre_flag` AND `dre_irq_en`, and `tc_irq` equals `tc_flag` AND `tc_irq_en`.
- R12: While `tx_en` is 0, `ser_out` is 1, a frame in progress is dropped, and no character loads; a waiting character stays held and loads after `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character written with `wr_stb` |
| nine_mode | input | 1 | 1 selects the 9-bit word format, sampled at load |
| ninth_bit | input | 1 | Extra data bit for the 9-bit format, sampled at load |
| tc_clr | input | 1 | Pulse that clears the transmit-complete flag |
| dre_irq_en | input | 1 | Enable for the holding-register-empty interrupt |
| tc_irq_en | input | 1 | Enable for the transmit-complete interrupt |
| ser_out | output | 1 | Serial line, idle high |
| dre_flag | output | 1 | Holding register empty |
| tc_flag | output | 1 | Transmit complete |
| dre_irq | output | 1 | Holding-register-empty interrupt request |
| tc_irq | output | 1 | Transmit-complete interrupt request |

## Verification
The properties assume that every input holds a clean binary value at each rising edge after reset. They also assume that a write, a tick and a flag clear can arrive in any combination on the same edge, because the design gives a fixed precedence among them. To keep the stability and start-bit properties meaningful, the stimulus changes inputs only on falling edges and drives `baud_tick` as single-cycle pulses with idle cycles between them. Same-edge collisions are created on purpose: a write during the ending stop tick, and a flag clear during a setting tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Bits added around the data field: start bit, stop bit, spare word bit
  localparam int unsigned FRAME_OVERHEAD = 3;

  function automatic int unsigned shift_width(input int unsigned data_w);
    return data_w + FRAME_OVERHEAD;
  endfunction

  function automatic int unsigned len_width(input int unsigned data_w);
    return $clog2(data_w + FRAME_OVERHEAD + 1);
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;

  // A write takes precedence: a load and a write on one edge leave it full
  always_comb begin
    full_d = full_q;
    if (load)   full_d = 1'b0;
    if (wr_stb) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (wr_stb) data_q <= wr_data;
  end

  assign hold_full = full_q;
  assign hold_data = data_q;

  assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> full_q);

  assert_waiting_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> full_q);

  assert_newest_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (data_q == $past(wr_data)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              nine_mode,
  input  logic              ninth_bit,
  output logic              load,
  output logic              frame_done,
  output logic              busy,
  output logic              ser_out
);

  localparam int unsigned SH_W  = sertx_pkg::shift_width(DATA_W);
  localparam int unsigned LEN_W = sertx_pkg::len_width(DATA_W);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(SH_W - 1);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(SH_W);

  logic [SH_W-1:0]  sh_q, sh_d, load_word;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             busy_q, busy_d;
  logic             step, last_bit;

  // Word assembled at load: bit 0 start, data LSB first, then word bit and fill
  genvar gi;
  generate
    for (gi = 0; gi < SH_W; gi++) begin : g_word
      if (gi == 0) begin : g_start
        assign load_word[gi] = 1'b0;
      end else if (gi <= DATA_W) begin : g_data
        assign load_word[gi] = hold_data[gi-1];
      end else if (gi == DATA_W + 1) begin : g_extra
        assign load_word[gi] = nine_mode ? ninth_bit : 1'b1;
      end else begin : g_stop
        assign load_word[gi] = 1'b1;
      end
    end
  endgenerate

  assign step       = busy_q && tx_en && baud_tick;
  assign last_bit   = (cnt_q == (len_q - 1'b1));
  assign frame_done = step && last_bit;
  assign load       = tx_en && hold_full && (!busy_q || frame_done);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    busy_d = busy_q;
    if (!tx_en) begin
      busy_d = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      sh_d   = load_word;
      cnt_d  = '0;
      len_d  = nine_mode ? LEN_LONG : LEN_SHORT;
    end else if (frame_done) begin
      busy_d = 1'b0;
    end else if (step) begin
      sh_d  = {1'b1, sh_q[SH_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      len_q  <= LEN_SHORT;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign busy    = busy_q;
  assign ser_out = !(busy_q && tx_en) || sh_q[0];

  assert_count_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));

  assert_start_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !sh_q[0] && cnt_q == '0));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !baud_tick && !hold_full) |=> $stable(sh_q));

  assert_disable_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy_q);

endmodule

// File: rtl/sertx_status.sv
module sertx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic hold_full,
  input  logic wr_stb,
  input  logic tc_clr,
  input  logic dre_irq_en,
  input  logic tc_irq_en,
  output logic tc_flag,
  output logic dre_flag,
  output logic dre_irq,
  output logic tc_irq
);

  logic tc_q, tc_d, tc_set;

  assign tc_set = frame_done && !hold_full && !wr_stb;

  always_comb begin
    tc_d = tc_q;
    if (wr_stb || tc_clr) tc_d = 1'b0;
    if (tc_set)           tc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign tc_flag  = tc_q;
  assign dre_flag = !hold_full;
  assign dre_irq  = dre_flag && dre_irq_en;
  assign tc_irq   = tc_q && tc_irq_en;

  assert_write_clears_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tc_q);

  assert_tc_only_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> $past(frame_done) && !hold_full);

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nine_mode,
  input  logic              ninth_bit,
  input  logic              tc_clr,
  input  logic              dre_irq_en,
  input  logic              tc_irq_en,
  output logic              ser_out,
  output logic              dre_flag,
  output logic              tc_flag,
  output logic              dre_irq,
  output logic              tc_irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              load, frame_done, busy, hold_full;
  logic [DATA_W-1:0] hold_data;

  // Reset asserts at once and releases on the second rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .load      (load),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_ni),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .nine_mode  (nine_mode),
    .ninth_bit  (ninth_bit),
    .load       (load),
    .frame_done (frame_done),
    .busy       (busy),
    .ser_out    (ser_out)
  );

  sertx_status u_status (
    .clk        (clk),
    .rst_n      (rst_ni),
    .frame_done (frame_done),
    .hold_full  (hold_full),
    .wr_stb     (wr_stb),
    .tc_clr     (tc_clr),
    .dre_irq_en (dre_irq_en),
    .tc_irq_en  (tc_irq_en),
    .tc_flag    (tc_flag),
    .dre_flag   (dre_flag),
    .dre_irq    (dre_irq),
    .tc_irq     (tc_irq)
  );

  assert_idle_line_high_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> ser_out);

  assert_dre_set_on_load_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (load && !wr_stb) |=> dre_flag);

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_done && hold_full && tx_en) |=> (busy && !ser_out));

endmodule

// File: tb/sertx_dbuf_bench.sv
module sertx_dbuf_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 150000;

  logic       clk, rst_n, tx_en, baud_tick, wr_stb, nine_mode, ninth_bit;
  logic       tc_clr, dre_irq_en, tc_irq_en;
  logic [7:0] wr_data;
  logic       ser_out, dre_flag, tc_flag, dre_irq, tc_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sertx_dbuf u_sertx_dbuf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_stb(wr_stb), .wr_data(wr_data), .nine_mode(nine_mode),
    .ninth_bit(ninth_bit), .tc_clr(tc_clr), .dre_irq_en(dre_irq_en),
    .tc_irq_en(tc_irq_en), .ser_out(ser_out), .dre_flag(dre_flag),
    .tc_flag(tc_flag), .dre_irq(dre_irq), .tc_irq(tc_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  // Sample the frame from its start bit up to the stop bit (final tick not sent)
  task automatic grab(input int len, output logic [10:0] bits, output int moved);
    logic held;
    bits  = '1;
    moved = 0;
    bits[0] = ser_out;
    for (int k = 1; k < len; k++) begin
      held = ser_out;
      @(negedge clk);
      if (ser_out !== held) moved++;
      tick();
      bits[k] = ser_out;
    end
  endtask

  function automatic logic [10:0] frame8(input logic [7:0] d);
    return {2'b11, d, 1'b0};
  endfunction

  function automatic logic [10:0] frame9(input logic [7:0] d, input logic b);
    return {1'b1, b, d, 1'b0};
  endfunction

  initial begin
    logic [10:0] bits;
    int moved;
    int bad8, bad9, badtc, badstable;

    rst_n = 1'b0; tx_en = 1'b1; baud_tick = 1'b0; wr_stb = 1'b0; wr_data = '0;
    nine_mode = 1'b0; ninth_bit = 1'b0; tc_clr = 1'b0;
    dre_irq_en = 1'b0; tc_irq_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: state after reset
    check(ser_out === 1'b1, "R1 ser_out", ser_out, 1);
    check(dre_flag === 1'b1, "R1 dre_flag", dre_flag, 1);
    check(tc_flag === 1'b0, "R1 tc_flag", tc_flag, 0);
    check({dre_irq, tc_irq} === 2'b00, "R1 irqs", {dre_irq, tc_irq}, 0);

    // R5 and R7: write while idle, then load one edge later
    @(negedge clk) begin wr_stb = 1'b1; wr_data = 8'hA5; end
    @(negedge clk) wr_stb = 1'b0;
    check(dre_flag === 1'b0, "R7 cleared by write", dre_flag, 0);
    check(ser_out === 1'b1, "R5 no start before load", ser_out, 1);
    @(negedge clk);
    check(ser_out === 1'b0, "R5 start bit after load", ser_out, 0);
    check(dre_flag === 1'b1, "R7 set on load", dre_flag, 1);
    grab(10, bits, moved);
    check(bits[9:0] === frame8(8'hA5)[9:0], "R2 first frame", bits, frame8(8'hA5));
    tick();
    check(tc_flag === 1'b1, "R9 tc after frame", tc_flag, 1);
    check(ser_out === 1'b1, "R12 idle high after frame", ser_out, 1);

    // R2 / R4 / R9 / R10: every 8-bit value
    bad8 = 0; badtc = 0; badstable = 0;
    for (int v = 0; v < 256; v++) begin
      write(8'(v));
      if (tc_flag !== 1'b0) badtc++;
      @(negedge clk);
      grab(10, bits, moved);
      if (bits[9:0] !== frame8(8'(v))[9:0]) bad8++;
      if (moved != 0) badstable++;
      tick();
      if (tc_flag !== 1'b1 || ser_out !== 1'b1) badtc++;
    end
    check(bad8 == 0, "R2 8-bit sweep", bad8, 0);
    check(badstable == 0, "R4 line stable between ticks", badstable, 0);
    check(badtc == 0, "R9 R10 tc per frame", badtc, 0);

    // R3: every 9-bit value, extra bit from ninth_bit
    nine_mode = 1'b1;
    bad9 = 0;
    for (int v = 0; v < 512; v++) begin
      ninth_bit = v[8];
      write(8'(v));
      @(negedge clk);
      grab(11, bits, moved);
      if (bits !== frame9(8'(v), v[8]) || moved != 0) bad9++;
      tick();
    end
    check(bad9 == 0, "R3 9-bit sweep", bad9, 0);

    // R6 / R7 / R9 / R3: back-to-back, ninth bit taken at load time
    ninth_bit = 1'b0;
    write(8'h3C);
    @(negedge clk);
    write(8'hC3);
    check(dre_flag === 1'b0, "R7 full while waiting", dre_flag, 0);
    ninth_bit = 1'b1;
    grab(11, bits, moved);
    check(bits === frame9(8'h3C, 1'b0), "R3 first frame ninth at load", bits,
          frame9(8'h3C, 1'b0));
    tick();
    check(ser_out === 1'b0, "R6 start follows stop", ser_out, 0);
    check(dre_flag === 1'b1, "R7 set at handoff", dre_flag, 1);
    check(tc_flag === 1'b0, "R9 no tc while waiting", tc_flag, 0);
    grab(11, bits, moved);
    check(bits === frame9(8'hC3, 1'b1), "R3 waiting frame ninth at load", bits,
          frame9(8'hC3, 1'b1));
    tick();
    check(tc_flag === 1'b1, "R9 tc after last frame", tc_flag, 1);

    // R8: overwrite of waiting character
    nine_mode = 1'b0;
    write(8'h11);
    @(negedge clk);
    write(8'h22);
    write(8'h9E);
    grab(10, bits, moved);
    check(bits[9:0] === frame8(8'h11)[9:0], "R8 frame in flight", bits, frame8(8'h11));
    tick();
    grab(10, bits, moved);
    check(bits[9:0] === frame8(8'h9E)[9:0], "R8 newest sent", bits, frame8(8'h9E));

    // R10: set wins over clear on the same edge, then clear alone
    @(negedge clk) begin baud_tick = 1'b1; tc_clr = 1'b1; end
    @(negedge clk) begin baud_tick = 1'b0; tc_clr = 1'b0; end
    check(tc_flag === 1'b1, "R10 set beats clear", tc_flag, 1);

    // R11: gating with both flags set
    for (int e = 0; e < 4; e++) begin
      dre_irq_en = e[0]; tc_irq_en = e[1];
      #1;
      check(dre_irq === e[0], "R11 dre_irq gating", dre_irq, e[0]);
      check(tc_irq === e[1], "R11 tc_irq gating", tc_irq, e[1]);
    end
    @(negedge clk) tc_clr = 1'b1;
    @(negedge clk) tc_clr = 1'b0;
    check(tc_flag === 1'b0, "R10 clear pulse", tc_flag, 0);
    check(tc_irq === 1'b0, "R11 tc_irq follows flag", tc_irq, 0);

    // R12: abort a frame by disabling
    write(8'h00);
    @(negedge clk);
    tick(); tick(); tick();
    check(ser_out === 1'b0, "R12 mid frame low bit", ser_out, 0);
    tx_en = 1'b0;
    #1;
    check(ser_out === 1'b1, "R12 high when disabled", ser_out, 1);
    idle(2);
    tx_en = 1'b1;
    idle(2);
    check(ser_out === 1'b1 && tc_flag === 1'b0, "R12 dropped frame", {tc_flag, ser_out}, 1);

    // R12: a write while disabled waits for enable
    tx_en = 1'b0;
    write(8'h5A);
    idle(3);
    check(ser_out === 1'b1, "R12 no load while disabled", ser_out, 1);
    check(dre_flag === 1'b0 && dre_irq === 1'b0, "R12 R11 held while disabled",
          {dre_flag, dre_irq}, 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(ser_out === 1'b0, "R12 loads on enable", ser_out, 0);
    grab(10, bits, moved);
    check(bits[9:0] === frame8(8'h5A)[9:0], "R12 held frame", bits, frame8(8'h5A));
    tick();
    check(tc_flag === 1'b1, "R9 tc after held frame", tc_flag, 1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule